// File: doc/BRIEF.md
# DSI Video-Mode Frame Timing Sequencer

This block produces the line and frame timing that a DSI host needs while it streams video. Horizontal intervals are counted in lane byte clock cycles. Vertical intervals are counted in whole lines. On every cycle the block reports which horizontal and vertical region is current: sync, back porch, active or front porch. It also emits one-cycle event strobes for the sync edges, a strobe that marks where the active-pixel packet of each line begins, and a flag that tells the lane logic when it may fall back to low-power signalling.

Settings arrive as plain configuration inputs:

- a power-up enable and a video/command select;
- the video mode type;
- a six-bit low-power permission mask;
- the pixel count of the active packet;
- the horizontal and vertical timing counts.

Software writes the settings while the power-up enable is low. Timing begins once the enable is set and video mode is selected. The timing settings are copied into shadow registers, so changes made during a frame do not disturb that frame. Packet assembly, pixel transport and the PHY sit downstream and consume these outputs.

Top module: `dsi_vid_timing`

## Requirements
- R1: While `pwr_on` is 0 or `cmd_sel` is 1, the block is idle: `run_o`=0, every strobe is 0, `lp_ok_o`=1 and both region outputs read 0. On the first clock edge that sees `pwr_on`=1 and `cmd_sel`=0, timing starts, and the following cycle is cycle 0 of line 0 with `run_o`=1.
- R2: A line lasts `hline_cyc` cycles, with 0 treated as 1. Region codes are 0 sync, 1 back porch, 2 active, 3 front porch. The line runs its first `hsa_cyc` cycles in sync, then `hbp_cyc` cycles in back porch, then ceil(`pkt_pix`*3/4) cycles in active (3 bytes per pixel over 4 lanes), and front porch for the rest. Each boundary is clamped to the end of the line.
- R3: A frame consists of `vsa_lines` sync lines, then `vbp_lines` back porch lines, then `vact_lines` active lines, then `vfp_lines` front porch lines, with a total of 0 treated as 1. The frame then repeats, and `vreg_o` uses the region codes of R2.
- R4: In every mode, `hs_start_o` pulses on cycle 0 of every line when `hsa_cyc`>0. `vs_start_o` pulses on cycle 0 of line 0 when `vsa_lines`>0.
- R5: With `vid_type`=0 (non-burst, sync pulses), `hs_end_o` pulses on cycle `hsa_cyc` of every line when 0<`hsa_cyc`<line length. `vs_end_o` pulses on cycle 0 of line `vsa_lines` when 0<`vsa_lines`<frame length.
- R6: With `vid_type` 1 (sync events), 2 (burst) or 3 (handled as burst), `hs_end_o` and `vs_end_o` never pulse.
- R7: `pix_pkt_o` pulses for one cycle at the first active cycle of each vertical-active line, and only when the active span is not empty. `pix_len_o` shows the packet pixel count in use for the current frame.
- R8: `lp_ok_o` is set by the `lp_en` bit of the current region. During vertical sync, back porch and front porch lines it is bits 0, 1 and 2. During active lines it is bit 5 in horizontal sync, bit 4 in horizontal back porch and bit 3 in horizontal front porch, and it is 0 in the horizontal active region.
- R9: When `hsa_cyc`+`hbp_cyc` is at least the line length, the active region is empty and no `pix_pkt_o` is produced.
- R10: All settings except `pwr_on` and `cmd_sel` are captured at the start and on the last cycle of each frame. A change made during a frame takes effect at the next frame.
- R11: Clearing `pwr_on` or setting `cmd_sel` during a frame makes the block idle from the next cycle. A later restart begins again at line 0, cycle 0, with freshly captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on | input | 1 | Power-up enable; 0 holds timing in reset |
| cmd_sel | input | 1 | 0 = video mode, 1 = command mode (timing idle) |
| vid_type | input | 2 | 0 sync pulses, 1 sync events, 2 burst |
| lp_en | input | 6 | Per-region low-power permission mask |
| pkt_pix | input | 14 | Active packet size in pixels |
| hsa_cyc | input | 12 | Horizontal sync time in byte clocks |
| hbp_cyc | input | 12 | Horizontal back porch time in byte clocks |
| hline_cyc | input | 12 | Total line time in byte clocks |
| vsa_lines | input | 11 | Vertical sync lines |
| vbp_lines | input | 11 | Vertical back porch lines |
| vact_lines | input | 11 | Vertical active lines |
| vfp_lines | input | 11 | Vertical front porch lines |
| run_o | output | 1 | Timing is running |
| hreg_o | output | 2 | Horizontal region code |
| vreg_o | output | 2 | Vertical region code |
| hs_start_o | output | 1 | Horizontal sync start strobe |
| hs_end_o | output | 1 | Horizontal sync end strobe |
| vs_start_o | output | 1 | Vertical sync start strobe |
| vs_end_o | output | 1 | Vertical sync end strobe |
| pix_pkt_o | output | 1 | Active-pixel packet start strobe |
| pix_len_o | output | 14 | Packet pixel count of the current frame |
| lp_ok_o | output | 1 | Lanes may enter low power |

## Verification
The hardest situation to reach is a setting change made in the middle of a running frame. It must leave the remainder of that frame untouched and then govern the frame after it. The stimulus starts a frame and changes the line length partway through line 1. It then counts line-start strobes over the rest of that frame at the old line length, and over one whole frame at the new length. Stopping and restarting in mid-frame is handled the same way: the bench toggles command mode at an arbitrary cycle and checks that the next active cycle shows the frame-start strobes.

// File: rtl/dvt_pkg.sv
// Shared definitions for the DSI video timing sequencer.
// Assumes: region codes are consumed directly as 2-bit values downstream.
package dvt_pkg;
    typedef enum logic [1:0] {
        RG_SYNC  = 2'd0,
        RG_BACK  = 2'd1,
        RG_ACT   = 2'd2,
        RG_FRONT = 2'd3
    } region_e;

    localparam logic [1:0] VT_PULSE = 2'd0;
    localparam logic [1:0] VT_EVENT = 2'd1;
    localparam logic [1:0] VT_BURST = 2'd2;

    localparam int LPB_VSYNC  = 0;
    localparam int LPB_VBACK  = 1;
    localparam int LPB_VFRONT = 2;
    localparam int LPB_HFRONT = 3;
    localparam int LPB_HBACK  = 4;
    localparam int LPB_HSYNC  = 5;
    localparam int LP_BITS    = 6;
endpackage

// File: rtl/dvt_shadow.sv
// Shadow register for the frame settings.
// Loads the live settings whenever 'load' is high, which is at start-up and on the
// last cycle of each frame, and holds them otherwise.
// Assumes: the settings are quasi-static and software-written.
module dvt_shadow #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    // Capture the settings at the frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/dvt_hcount.sv
// Horizontal counter in lane byte clock cycles.
// Runs while 'en' is high and wraps after hline_eff cycles. It is held at zero while idle.
// Assumes: hline_eff is never zero (the caller substitutes 1).
module dvt_hcount #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [HW-1:0] hline_eff,
    output logic [HW-1:0] hc,
    output logic          line_end
);
    assign line_end = (hc == hline_eff - HW'(1));

    // Advance through the line; restart at zero at the end of the line or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hc <= '0;
        end else if (line_end) begin
            hc <= '0;
        end else begin
            hc <= hc + HW'(1);
        end
    end

    // R2
    hc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (hc < hline_eff));
endmodule

// File: rtl/dvt_vcount.sv
// Vertical line counter.
// Steps once per completed line and wraps after vtot_eff lines.
// Assumes: vtot_eff is never zero.
module dvt_vcount #(
    parameter int VCW = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           step,
    input  logic [VCW-1:0] vtot_eff,
    output logic [VCW-1:0] vc,
    output logic           frame_end
);
    assign frame_end = step && (vc == vtot_eff - VCW'(1));

    // Count finished lines; return to line 0 at the end of the frame or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            vc <= '0;
        end else if (frame_end) begin
            vc <= '0;
        end else if (step) begin
            vc <= vc + VCW'(1);
        end
    end

    // R3
    vc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (vc < vtot_eff));
endmodule

// File: rtl/dvt_decode.sv
// Region and strobe decoder.
// Turns the counters and the shadowed settings into region codes, sync strobes,
// the packet-start strobe and the low-power permission flag.
// Assumes: every boundary is clamped to the line end, so any sum of settings is legal.
module dvt_decode
    import dvt_pkg::*;
#(
    parameter int HW        = 12,
    parameter int VW        = 11,
    parameter int PKTW      = 14,
    parameter int PIX_BYTES = 3,
    parameter int LANES     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act,
    input  logic [1:0]         vtype,
    input  logic [LP_BITS-1:0] lp_en,
    input  logic [PKTW-1:0]    pkt,
    input  logic [HW-1:0]      hsa,
    input  logic [HW-1:0]      hbp,
    input  logic [HW-1:0]      hline_eff,
    input  logic [VW-1:0]      vsa,
    input  logic [VW-1:0]      vbp,
    input  logic [VW-1:0]      vact,
    input  logic [VW+1:0]      vtot_eff,
    input  logic [HW-1:0]      hc,
    input  logic [VW+1:0]      vc,
    output region_e            hreg,
    output region_e            vreg,
    output logic               hs_start,
    output logic               hs_end,
    output logic               vs_start,
    output logic               vs_end,
    output logic               pix_pkt,
    output logic               lp_ok
);
    localparam int CW  = ((HW > PKTW) ? HW : PKTW) + 6;
    localparam int VCW = VW + 2;

    function automatic logic [CW-1:0] cmin(input logic [CW-1:0] a, input logic [CW-1:0] b);
        return (a < b) ? a : b;
    endfunction

    logic [CW-1:0]  pix_cyc, hl, b_sync, b_back, b_act, hcw;
    logic [VCW-1:0] v_sync, v_back, v_act;
    logic           pulse;

    // Horizontal boundaries in byte clocks, each clamped to the line length.
    always_comb begin
        pix_cyc = (CW'(pkt) * CW'(PIX_BYTES) + CW'(LANES - 1)) / CW'(LANES);
        hl      = CW'(hline_eff);
        b_sync  = cmin(CW'(hsa), hl);
        b_back  = cmin(CW'(hsa) + CW'(hbp), hl);
        b_act   = cmin(CW'(hsa) + CW'(hbp) + pix_cyc, hl);
        hcw     = CW'(hc);
    end

    // Cumulative vertical boundaries in lines.
    always_comb begin
        v_sync = VCW'(vsa);
        v_back = v_sync + VCW'(vbp);
        v_act  = v_back + VCW'(vact);
    end

    // Region decode; idle reports sync.
    always_comb begin
        hreg = RG_SYNC;
        vreg = RG_SYNC;
        if (act) begin
            if (hcw < b_sync)      hreg = RG_SYNC;
            else if (hcw < b_back) hreg = RG_BACK;
            else if (hcw < b_act)  hreg = RG_ACT;
            else                   hreg = RG_FRONT;
            if (vc < v_sync)       vreg = RG_SYNC;
            else if (vc < v_back)  vreg = RG_BACK;
            else if (vc < v_act)   vreg = RG_ACT;
            else                   vreg = RG_FRONT;
        end
    end

    // Event strobes; the end strobes exist only in sync-pulse mode.
    always_comb begin
        pulse    = (vtype == VT_PULSE);
        hs_start = act && (hc == '0) && (hsa != '0);
        hs_end   = act && pulse && (hsa != '0) && (CW'(hsa) < hl) && (hcw == CW'(hsa));
        vs_start = act && (hc == '0) && (vc == '0) && (vsa != '0);
        vs_end   = act && pulse && (hc == '0) && (vsa != '0)
                   && (VCW'(vsa) < vtot_eff) && (vc == VCW'(vsa));
        pix_pkt  = act && (vreg == RG_ACT) && (b_act > b_back) && (hcw == b_back);
    end

    // Low-power permission from the mask bit of the current region.
    always_comb begin
        lp_ok = 1'b1;
        if (act) begin
            case (vreg)
                RG_SYNC:  lp_ok = lp_en[LPB_VSYNC];
                RG_BACK:  lp_ok = lp_en[LPB_VBACK];
                RG_FRONT: lp_ok = lp_en[LPB_VFRONT];
                default: begin
                    case (hreg)
                        RG_SYNC:  lp_ok = lp_en[LPB_HSYNC];
                        RG_BACK:  lp_ok = lp_en[LPB_HBACK];
                        RG_FRONT: lp_ok = lp_en[LPB_HFRONT];
                        default:  lp_ok = 1'b0;
                    endcase
                end
            endcase
        end
    end

    // R6
    evt_no_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vtype != VT_PULSE) |-> !(hs_end || vs_end));
endmodule

// File: rtl/dsi_vid_timing.sv
// DSI video-mode frame timing sequencer (top).
// Runs while powered up in video mode. The settings are shadowed per frame, counters
// give the line and frame position, and the decoder derives regions and strobes.
// Assumes: clk is the lane byte clock; settings are static while pwr_on is low.
module dsi_vid_timing
    import dvt_pkg::*;
#(
    parameter int HW        = 12,
    parameter int VW        = 11,
    parameter int PKTW      = 14,
    parameter int PIX_BYTES = 3,
    parameter int LANES     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_on,
    input  logic            cmd_sel,
    input  logic [1:0]      vid_type,
    input  logic [5:0]      lp_en,
    input  logic [PKTW-1:0] pkt_pix,
    input  logic [HW-1:0]   hsa_cyc,
    input  logic [HW-1:0]   hbp_cyc,
    input  logic [HW-1:0]   hline_cyc,
    input  logic [VW-1:0]   vsa_lines,
    input  logic [VW-1:0]   vbp_lines,
    input  logic [VW-1:0]   vact_lines,
    input  logic [VW-1:0]   vfp_lines,
    output logic            run_o,
    output logic [1:0]      hreg_o,
    output logic [1:0]      vreg_o,
    output logic            hs_start_o,
    output logic            hs_end_o,
    output logic            vs_start_o,
    output logic            vs_end_o,
    output logic            pix_pkt_o,
    output logic [PKTW-1:0] pix_len_o,
    output logic            lp_ok_o
);
    localparam int VCW = VW + 2;
    localparam int SDW = 2 + LP_BITS + PKTW + 3 * HW + 4 * VW;

    logic             run, active_q, load, line_end, frame_end;
    logic [SDW-1:0]   cfg_d, cfg_q;
    logic [1:0]       vtype_q;
    logic [5:0]       lp_q;
    logic [PKTW-1:0]  pkt_q;
    logic [HW-1:0]    hsa_q, hbp_q, hline_q, hline_eff, hc;
    logic [VW-1:0]    vsa_q, vbp_q, vact_q, vfp_q;
    logic [VCW-1:0]   vtot, vtot_eff, vc;
    region_e          hreg, vreg;

    assign run = pwr_on && !cmd_sel;

    // Track whether timing ran in the previous cycle; the first running cycle restarts the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= run;
    end

    assign load  = !active_q || frame_end;
    assign cfg_d = {vid_type, lp_en, pkt_pix, hsa_cyc, hbp_cyc, hline_cyc,
                    vsa_lines, vbp_lines, vact_lines, vfp_lines};

    dvt_shadow #(.DW(SDW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(load), .d(cfg_d), .q(cfg_q)
    );

    assign {vtype_q, lp_q, pkt_q, hsa_q, hbp_q, hline_q,
            vsa_q, vbp_q, vact_q, vfp_q} = cfg_q;

    // Substitute a minimum of one for zero line and frame lengths.
    always_comb begin
        hline_eff = (hline_q == '0) ? HW'(1) : hline_q;
        vtot      = VCW'(vsa_q) + VCW'(vbp_q) + VCW'(vact_q) + VCW'(vfp_q);
        vtot_eff  = (vtot == '0) ? VCW'(1) : vtot;
    end

    dvt_hcount #(.HW(HW)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .en(active_q), .hline_eff(hline_eff),
        .hc(hc), .line_end(line_end)
    );

    dvt_vcount #(.VCW(VCW)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .en(active_q), .step(line_end),
        .vtot_eff(vtot_eff), .vc(vc), .frame_end(frame_end)
    );

    dvt_decode #(.HW(HW), .VW(VW), .PKTW(PKTW), .PIX_BYTES(PIX_BYTES), .LANES(LANES)) u_dec (
        .clk(clk), .rst_n(rst_n), .act(active_q), .vtype(vtype_q), .lp_en(lp_q),
        .pkt(pkt_q), .hsa(hsa_q), .hbp(hbp_q), .hline_eff(hline_eff),
        .vsa(vsa_q), .vbp(vbp_q), .vact(vact_q), .vtot_eff(vtot_eff),
        .hc(hc), .vc(vc), .hreg(hreg), .vreg(vreg),
        .hs_start(hs_start_o), .hs_end(hs_end_o), .vs_start(vs_start_o),
        .vs_end(vs_end_o), .pix_pkt(pix_pkt_o), .lp_ok(lp_ok_o)
    );

    assign run_o     = active_q;
    assign hreg_o    = hreg;
    assign vreg_o    = vreg;
    assign pix_len_o = pkt_q;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> (!hs_start_o && !vs_start_o && !pix_pkt_o && lp_ok_o));
    // R2
    horder_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && $past(run_o) && (hreg != $past(hreg))) |-> ((hreg > $past(hreg)) || (hc == '0)));
    // R7
    pix_in_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_pkt_o |-> (hreg == RG_ACT && vreg == RG_ACT));
    // R11
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> (hc == '0 && vc == '0));
endmodule

// File: tb/dsi_vid_timing_test.sv
module dsi_vid_timing_test;
    logic        clk = 1'b0, rst_n = 1'b0, pwr_on = 1'b0, cmd_sel = 1'b0;
    logic [1:0]  vid_type = '0;
    logic [5:0]  lp_en = '0;
    logic [13:0] pkt_pix = '0;
    logic [11:0] hsa_cyc = '0, hbp_cyc = '0, hline_cyc = '0;
    logic [10:0] vsa_lines = '0, vbp_lines = '0, vact_lines = '0, vfp_lines = '0;
    logic        run_o, hs_start_o, hs_end_o, vs_start_o, vs_end_o, pix_pkt_o, lp_ok_o;
    logic [1:0]  hreg_o, vreg_o;
    logic [13:0] pix_len_o;

    int checks = 0, errors = 0;
    bit done = 0;

    dsi_vid_timing uut (.*);

    always #10 clk = ~clk;

    // Configuration table: type, hsa, hbp, hline, pkt, vsa, vbp, vact, vfp, lp mask
    localparam int NR = 5;
    localparam int T_TYPE [NR] = '{0, 1, 2, 0, 0};
    localparam int T_HSA  [NR] = '{3, 2, 4, 6, 1};
    localparam int T_HBP  [NR] = '{2, 3, 4, 6, 0};
    localparam int T_HL   [NR] = '{20, 16, 24, 10, 8};
    localparam int T_PKT  [NR] = '{8, 4, 20, 8, 16};
    localparam int T_VSA  [NR] = '{1, 2, 1, 0, 2};
    localparam int T_VBP  [NR] = '{2, 1, 1, 2, 0};
    localparam int T_VACT [NR] = '{3, 2, 4, 2, 2};
    localparam int T_VFP  [NR] = '{1, 2, 1, 1, 0};
    localparam int T_LP   [NR] = '{7, 56, 42, 63, 21};

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic load_row(input int i);
        vid_type = 2'(T_TYPE[i]); hsa_cyc = 12'(T_HSA[i]); hbp_cyc = 12'(T_HBP[i]);
        hline_cyc = 12'(T_HL[i]); pkt_pix = 14'(T_PKT[i]); vsa_lines = 11'(T_VSA[i]);
        vbp_lines = 11'(T_VBP[i]); vact_lines = 11'(T_VACT[i]); vfp_lines = 11'(T_VFP[i]);
        lp_en = 6'(T_LP[i]);
    endtask

    task automatic run_row(input int i);
        int hl, vt, pc, s, b, a, m, f;
        int n_hss, n_hse, n_vss, n_vse, n_pix, n_act, n_lp;
        int e_lp;
        hl = (T_HL[i] == 0) ? 1 : T_HL[i];
        vt = T_VSA[i] + T_VBP[i] + T_VACT[i] + T_VFP[i];
        pc = (T_PKT[i] * 3 + 3) / 4;
        s = imin(T_HSA[i], hl);
        b = imin(T_HSA[i] + T_HBP[i], hl);
        a = imin(T_HSA[i] + T_HBP[i] + pc, hl);
        m = T_LP[i];
        f = hl * vt;
        @(negedge clk); pwr_on = 1'b0; load_row(i);
        @(negedge clk);
        check("R1 idle run_o", int'(run_o), 0);
        pwr_on = 1'b1;
        n_hss = 0; n_hse = 0; n_vss = 0; n_vse = 0; n_pix = 0; n_act = 0; n_lp = 0;
        for (int c = 0; c < f; c++) begin
            @(negedge clk);
            if (c == 0) begin
                check("R1 run_o at cycle 0", int'(run_o), 1);
                check("R7 pix_len", int'(pix_len_o), T_PKT[i]);
            end
            n_hss += int'(hs_start_o); n_hse += int'(hs_end_o);
            n_vss += int'(vs_start_o); n_vse += int'(vs_end_o);
            n_pix += int'(pix_pkt_o);  n_lp += int'(lp_ok_o);
            n_act += int'(hreg_o == 2'd2 && vreg_o == 2'd2);
        end
        e_lp = ((m >> 0) & 1) * T_VSA[i] * hl + ((m >> 1) & 1) * T_VBP[i] * hl
             + ((m >> 2) & 1) * T_VFP[i] * hl
             + T_VACT[i] * (((m >> 5) & 1) * s + ((m >> 4) & 1) * (b - s) + ((m >> 3) & 1) * (hl - a));
        check("R4 hs_start count", n_hss, (T_HSA[i] > 0) ? vt : 0);
        check("R4 vs_start count", n_vss, (T_VSA[i] > 0) ? 1 : 0);
        if (T_TYPE[i] == 0) begin
            check("R5 hs_end count", n_hse, (T_HSA[i] > 0 && T_HSA[i] < hl) ? vt : 0);
            check("R5 vs_end count", n_vse, (T_VSA[i] > 0 && T_VSA[i] < vt) ? 1 : 0);
        end else begin
            check("R6 hs_end count", n_hse, 0);
            check("R6 vs_end count", n_vse, 0);
        end
        if (a > b) check("R7 pix_pkt count", n_pix, T_VACT[i]);
        else       check("R9 pix_pkt count clamped", n_pix, 0);
        check("R2 R3 active cycles", n_act, T_VACT[i] * (a - b));
        check("R8 lp_ok cycles", n_lp, e_lp);
        @(negedge clk);
        check("R3 frame wraps hs_start", int'(hs_start_o), (T_HSA[i] > 0) ? 1 : 0);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 reset run_o", int'(run_o), 0);
        check("R1 reset lp_ok", int'(lp_ok_o), 1);
        check("R1 reset hs_start", int'(hs_start_o), 0);
        rst_n = 1'b1;
        // Powered but in command mode stays idle.
        pwr_on = 1'b1; cmd_sel = 1'b1; load_row(0);
        repeat (4) @(negedge clk);
        check("R1 cmd mode idle run_o", int'(run_o), 0);
        check("R1 cmd mode idle hreg", int'(hreg_o), 0);
        cmd_sel = 1'b0; pwr_on = 1'b0;
        for (int i = 0; i < NR; i++) run_row(i);

        // R10: change line length in mid-frame, effective next frame.
        @(negedge clk); pwr_on = 1'b0; load_row(0);
        @(negedge clk); pwr_on = 1'b1;
        repeat (31) @(negedge clk);
        hline_cyc = 12'd12;
        n = 0;
        repeat (109) begin @(negedge clk); n += int'(hs_start_o); end
        check("R10 old line length holds", n, 5);
        n = 0;
        repeat (84) begin @(negedge clk); n += int'(hs_start_o); end
        check("R10 new line length applied", n, 7);
        @(negedge clk);
        check("R10 next frame start", int'(vs_start_o), 1);

        // R11: stop in mid-frame, then restart from frame start.
        repeat (5) @(negedge clk);
        cmd_sel = 1'b1;
        @(negedge clk);
        check("R11 stop run_o", int'(run_o), 0);
        check("R11 stop lp_ok", int'(lp_ok_o), 1);
        check("R11 stop hs_start", int'(hs_start_o), 0);
        cmd_sel = 1'b0;
        @(negedge clk);
        check("R11 restart run_o", int'(run_o), 1);
        check("R11 restart vs_start", int'(vs_start_o), 1);
        check("R11 restart hreg", int'(hreg_o), 0);

        // R2: zero line length behaves as one cycle per line.
        @(negedge clk); pwr_on = 1'b0;
        vid_type = 2'd0; hsa_cyc = 12'd1; hbp_cyc = 12'd0; hline_cyc = 12'd0; pkt_pix = 14'd0;
        vsa_lines = 11'd1; vbp_lines = 11'd1; vact_lines = 11'd0; vfp_lines = 11'd1;
        @(negedge clk); pwr_on = 1'b1;
        begin
            int hs, vs, he, ve;
            hs = 0; vs = 0; he = 0; ve = 0;
            repeat (6) begin
                @(negedge clk);
                hs += int'(hs_start_o); vs += int'(vs_start_o);
                he += int'(hs_end_o);   ve += int'(vs_end_o);
            end
            check("R2 zero line hs_start", hs, 6);
            check("R3 zero line vs_start", vs, 2);
            check("R5 zero line hs_end", he, 0);
            check("R5 zero line vs_end", ve, 2);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule